// File: doc/BRIEF.md
# Per-Thread Instruction Fetch Line Buffer

This block keeps one cache-line-sized buffer for each hardware thread of a fetch stage and decides when a thread needs a new line from the instruction cache. The fetch logic presents a thread number and a program counter. The block clears the offset bits of that counter to form a line address. If the thread's buffer already holds that line, the block reports a hit and returns the line. If it does not, the block sends a read over a valid/ready request port. Each read carries the thread number and a 4-bit request tag.

When the cache refuses a read, the block parks it in one retry slot that all threads share and raises a global blocked flag. While that flag is set, no new read starts. A retry strobe from the cache replays the parked read. Responses come back in a single beat. Each response is tagged with a thread and a request tag, and the block keeps it only if it matches what that thread is still waiting for. A per-thread squash input cancels the thread's outstanding read and frees the retry slot if that thread owns it. Responses that are dropped are counted.

Top module: `fetch_line_buf`

## Requirements
- R1: The line address sent with a new read is the fetch PC with its low log2(BLK_BYTES) bits forced to zero. With the default 32-byte line, these are bits 4..0.
- R2: `fetch_hit` is high when `fetch_req` is set, the thread's buffer is valid and its stored line address equals the aligned PC. A hit starts no read, and `line_out` always shows the buffer of `fetch_tid`.
- R3: A new read starts only when all of the following hold: a fetch is requested, it misses, the blocked flag is clear, the thread has no read outstanding, the thread is not being squashed in that cycle, and it is not the case that `irq_pending` is high while PC bits 1..0 are 00.
- R4: Starting a new read stores the line address for the thread and marks its buffer invalid. The read takes its tag from a 4-bit counter that starts at 0, advances by one per new read (not per replay) and wraps from 15 to 0. A read accepted by the cache sets the thread's `waiting_o` bit from the next cycle on.
- R5: A new read that is refused (`creq_valid` high and `creq_ready` low) is placed in the retry slot together with its thread and tag, and `cache_blocked` rises on the next cycle.
- R6: When `cache_retry` is high and the slot is full, the block presents the slot's address, thread and tag again. If the cache accepts it, the slot empties and `cache_blocked` falls. If the cache refuses it, both stay as they were.
- R7: A retry strobe that arrives while the slot is empty, or whose slot owner is squashed in the same cycle, clears `cache_blocked` and sends nothing.
- R8: `squash[t]` clears the outstanding read of thread t. It also empties the retry slot if thread t owns it, but it leaves `cache_blocked` set. A squash in the same cycle as a fetch by the same thread suppresses that fetch's read.
- R9: A response is kept when its thread is waiting, its tag equals that thread's outstanding tag and the thread is not squashed in that cycle. The line is then stored, the buffer is marked valid and `waiting_o` clears.
- R10: Every other response is dropped, and `drop_cnt` goes up by one on the next cycle.
- R11: After reset every buffer is invalid, no thread is waiting, `cache_blocked` is low, `drop_cnt` is 0 and the first tag issued is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch lookup valid this cycle |
| fetch_tid | input | TID_W | Thread of the lookup |
| fetch_pc | input | ADDR_W | Fetch program counter |
| irq_pending | input | 1 | Interrupt pending, holds new reads for PCs with bits 1..0 equal to 00 |
| fetch_hit | output | 1 | Lookup hits the thread's buffer |
| line_out | output | LINE_W | Buffer contents of `fetch_tid` |
| creq_valid | output | 1 | Cache read request valid |
| creq_ready | input | 1 | Cache accepts the request |
| creq_addr | output | ADDR_W | Line-aligned read address |
| creq_tid | output | TID_W | Thread of the read |
| creq_id | output | ID_W | Request tag |
| cache_retry | input | 1 | Strobe from the cache to replay a refused read |
| cresp_valid | input | 1 | Response valid |
| cresp_tid | input | TID_W | Response thread |
| cresp_id | input | ID_W | Response tag |
| cresp_line | input | LINE_W | Whole returned line |
| squash | input | NTHREADS | Per-thread squash |
| waiting_o | output | NTHREADS | Per-thread read outstanding |
| cache_blocked | output | 1 | Global blocked flag |
| drop_cnt | output | CNT_W | Count of dropped responses |

## Verification
Two events can land on the same clock edge. One is a replayed read for one thread being accepted while a response for the other thread arrives. The other is a squash that coincides with the response it makes stale. The bench forces both on purpose. It accepts a retry for thread 1 in the same cycle as a response for thread 0 that is stale. It also squashes thread 0 in exactly the cycle its matching response arrives. A behavioural model then checks, on every clock, that the response is dropped and counted, that no line is written and that the replayed thread becomes waiting. A long random phase then mixes retries, squashes and responses freely.

// File: rtl/fetch_line_buf.sv
module fetch_line_buf #(
  parameter int NTHREADS  = 2,
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32,
  parameter int ID_W      = 4,
  parameter int CNT_W     = 16,
  localparam int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int LINE_W   = BLK_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_req,
  input  logic [TID_W-1:0]    fetch_tid,
  input  logic [ADDR_W-1:0]   fetch_pc,
  input  logic                irq_pending,
  output logic                fetch_hit,
  output logic [LINE_W-1:0]   line_out,
  output logic                creq_valid,
  input  logic                creq_ready,
  output logic [ADDR_W-1:0]   creq_addr,
  output logic [TID_W-1:0]    creq_tid,
  output logic [ID_W-1:0]     creq_id,
  input  logic                cache_retry,
  input  logic                cresp_valid,
  input  logic [TID_W-1:0]    cresp_tid,
  input  logic [ID_W-1:0]     cresp_id,
  input  logic [LINE_W-1:0]   cresp_line,
  input  logic [NTHREADS-1:0] squash,
  output logic [NTHREADS-1:0] waiting_o,
  output logic                cache_blocked,
  output logic [CNT_W-1:0]    drop_cnt
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);

  logic [NTHREADS-1:0] valid_q, wait_q;
  logic [ADDR_W-1:0]   blk_q  [NTHREADS];
  logic [ID_W-1:0]     oid_q  [NTHREADS];
  logic [LINE_W-1:0]   line_q [NTHREADS];

  logic              slot_v;
  logic [TID_W-1:0]  slot_tid;
  logic [ADDR_W-1:0] slot_addr;
  logic [ID_W-1:0]   slot_id;
  logic              blocked_q;
  logic [ID_W-1:0]   idc_q;
  logic [CNT_W-1:0]  drop_q;

  logic [ADDR_W-1:0] aligned;
  logic irq_hold, new_go, resend, accepted, resp_ok, retry_empty;

  assign aligned   = fetch_pc & ~OFF_MASK;
  assign fetch_hit = fetch_req && valid_q[fetch_tid] && (blk_q[fetch_tid] == aligned);
  assign line_out  = line_q[fetch_tid];
  assign irq_hold  = irq_pending && (fetch_pc[1:0] == 2'b00);

  assign new_go = fetch_req && !fetch_hit && !blocked_q && !irq_hold &&
                  !wait_q[fetch_tid] && !squash[fetch_tid];
  assign resend = cache_retry && slot_v && !squash[slot_tid];
  assign retry_empty = cache_retry && (!slot_v || squash[slot_tid]);

  assign creq_valid = new_go || resend;
  assign creq_addr  = resend ? slot_addr : aligned;
  assign creq_tid   = resend ? slot_tid  : fetch_tid;
  assign creq_id    = resend ? slot_id   : idc_q;
  assign accepted   = creq_valid && creq_ready;

  assign resp_ok = cresp_valid && wait_q[cresp_tid] &&
                   (cresp_id == oid_q[cresp_tid]) && !squash[cresp_tid];

  assign waiting_o     = wait_q;
  assign cache_blocked = blocked_q;
  assign drop_cnt      = drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wait_q  <= '0;
      for (int t = 0; t < NTHREADS; t++) begin
        blk_q[t]  <= '0;
        oid_q[t]  <= '0;
        line_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NTHREADS; t++) begin
        if (new_go && fetch_tid == TID_W'(t)) begin
          blk_q[t]   <= aligned;
          valid_q[t] <= 1'b0;
          oid_q[t]   <= idc_q;
        end
        if (squash[t]) begin
          wait_q[t] <= 1'b0;
        end else if (accepted && creq_tid == TID_W'(t)) begin
          wait_q[t] <= 1'b1;
        end else if (resp_ok && cresp_tid == TID_W'(t)) begin
          wait_q[t]  <= 1'b0;
          valid_q[t] <= 1'b1;
          line_q[t]  <= cresp_line;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v    <= 1'b0;
      slot_tid  <= '0;
      slot_addr <= '0;
      slot_id   <= '0;
      blocked_q <= 1'b0;
      idc_q     <= '0;
      drop_q    <= '0;
    end else begin
      if (retry_empty) blocked_q <= 1'b0;
      if (resend && creq_ready) begin
        slot_v    <= 1'b0;
        blocked_q <= 1'b0;
      end
      if (slot_v && squash[slot_tid]) slot_v <= 1'b0;
      if (new_go) begin
        idc_q <= idc_q + ID_W'(1);
        if (!creq_ready) begin
          slot_v    <= 1'b1;
          slot_tid  <= fetch_tid;
          slot_addr <= aligned;
          slot_id   <= idc_q;
          blocked_q <= 1'b1;
        end
      end
      if (cresp_valid && !resp_ok) drop_q <= drop_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fetch_line_buf_chk.sv
module fetch_line_buf_chk #(
  parameter int NTHREADS  = 2,
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32,
  parameter int CNT_W     = 16,
  localparam int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int OFF_W    = $clog2(BLK_BYTES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   fetch_pc,
  input logic                irq_pending,
  input logic                fetch_hit,
  input logic                creq_valid,
  input logic                creq_ready,
  input logic [ADDR_W-1:0]   creq_addr,
  input logic [TID_W-1:0]    creq_tid,
  input logic                cache_retry,
  input logic                cresp_valid,
  input logic [TID_W-1:0]    cresp_tid,
  input logic [NTHREADS-1:0] waiting_o,
  input logic                cache_blocked,
  input logic [CNT_W-1:0]    drop_cnt
);
  a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid |-> (creq_addr[OFF_W-1:0] == '0));

  a_r2_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit && !cache_blocked |-> !creq_valid);

  a_r3_blocked_only_replay: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked && creq_valid |-> cache_retry);

  a_r3_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending && fetch_pc[1:0] == 2'b00 && !cache_blocked |-> !creq_valid);

  a_r4_accept_waits: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid && creq_ready |=> waiting_o[$past(creq_tid)]);

  a_r5_refuse_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid && !creq_ready |=> cache_blocked);

  a_r10_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    cresp_valid && !waiting_o[cresp_tid] |=> drop_cnt == $past(drop_cnt) + CNT_W'(1));
endmodule

bind fetch_line_buf fetch_line_buf_chk #(
  .NTHREADS(NTHREADS), .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/fetch_line_buf_tb_top.sv
`timescale 1ns/1ps
module fetch_line_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req, fetch_tid, irq_pending, creq_ready, cache_retry;
  logic cresp_valid, cresp_tid;
  logic [31:0]  fetch_pc;
  logic [3:0]   cresp_id;
  logic [255:0] cresp_line;
  logic [1:0]   squash;
  logic fetch_hit, creq_valid, cache_blocked, creq_tid;
  logic [255:0] line_out;
  logic [31:0]  creq_addr;
  logic [3:0]   creq_id;
  logic [1:0]   waiting_o;
  logic [15:0]  drop_cnt;

  always #2.5 clk = ~clk;

  fetch_line_buf dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  bit          m_valid [2];
  bit          m_wait  [2];
  bit [31:0]   m_blk   [2];
  bit [3:0]    m_oid   [2];
  bit [255:0]  m_line  [2];
  bit          m_sv, m_st, m_blocked;
  bit [31:0]   m_sa;
  bit [3:0]    m_sid, m_idc;
  int          m_drop;

  task automatic chk(string nm, logic [255:0] a, logic [255:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", nm, a, e);
    end
  endtask

  task automatic idle();
    fetch_req = 0; fetch_tid = 0; fetch_pc = 0; irq_pending = 0;
    creq_ready = 1; cache_retry = 0; cresp_valid = 0; cresp_tid = 0;
    cresp_id = 0; cresp_line = '0; squash = 2'b00;
  endtask

  task automatic cycle();
    bit [31:0] al;
    bit e_hit, hold, e_new, e_res, acc, ok, ctid;
    #1;
    al    = fetch_pc & ~32'h1f;
    e_hit = fetch_req && m_valid[fetch_tid] && m_blk[fetch_tid] == al;
    hold  = irq_pending && fetch_pc[1:0] == 2'b00;
    e_new = fetch_req && !e_hit && !m_blocked && !hold && !m_wait[fetch_tid] && !squash[fetch_tid];
    e_res = cache_retry && m_sv && !squash[m_st];
    chk("R2 fetch_hit", fetch_hit, e_hit);
    chk("R2 line_out", line_out, m_line[fetch_tid]);
    chk("R3 creq_valid", creq_valid, e_new || e_res);
    if (e_res) begin
      chk("R6 replay addr", creq_addr, m_sa);
      chk("R6 replay tid", creq_tid, m_st);
      chk("R6 replay id", creq_id, m_sid);
    end else if (e_new) begin
      chk("R1 creq_addr", creq_addr, al);
      chk("R4 creq_tid", creq_tid, fetch_tid);
      chk("R4 creq_id", creq_id, m_idc);
    end
    chk("R4 waiting_o", waiting_o, {m_wait[1], m_wait[0]});
    chk("R5 cache_blocked", cache_blocked, m_blocked);
    chk("R10 drop_cnt", drop_cnt, 16'(m_drop));
    acc  = (e_new || e_res) && creq_ready;
    ctid = e_res ? m_st : fetch_tid;
    ok   = cresp_valid && m_wait[cresp_tid] && cresp_id == m_oid[cresp_tid] && !squash[cresp_tid];
    @(posedge clk);
    if (cache_retry && (!m_sv || squash[m_st])) m_blocked = 0;
    if (e_res && creq_ready) begin m_sv = 0; m_blocked = 0; end
    if (m_sv && squash[m_st]) m_sv = 0;
    if (e_new) begin
      m_blk[fetch_tid] = al; m_valid[fetch_tid] = 0; m_oid[fetch_tid] = m_idc;
      if (!creq_ready) begin
        m_sv = 1; m_st = fetch_tid; m_sa = al; m_sid = m_idc; m_blocked = 1;
      end
      m_idc = m_idc + 4'd1;
    end
    for (int t = 0; t < 2; t++) begin
      if (squash[t]) m_wait[t] = 0;
      else if (acc && ctid == 1'(t)) m_wait[t] = 1;
      else if (ok && cresp_tid == 1'(t)) begin
        m_wait[t] = 0; m_valid[t] = 1; m_line[t] = cresp_line;
      end
    end
    if (cresp_valid && !ok) m_drop++;
    @(negedge clk);
  endtask

  task automatic fetch(bit tid, bit [31:0] pc, bit rdy);
    idle(); fetch_req = 1; fetch_tid = tid; fetch_pc = pc; creq_ready = rdy;
  endtask

  task automatic resp(bit tid, bit [3:0] id, bit [255:0] ln);
    cresp_valid = 1; cresp_tid = tid; cresp_id = id; cresp_line = ln;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11 reset blocked", cache_blocked, 0);
    chk("R11 reset waiting", waiting_o, 0);
    chk("R11 reset drop", drop_cnt, 0);
    @(negedge clk);
    // first read, tag 0
    fetch(0, 32'h104, 1); #1; chk("R11 first tag", creq_id, 0); chk("R1 addr", creq_addr, 32'h100);
    cycle();
    idle(); resp(0, 0, {8{32'hA5A5_0001}}); cycle();
    fetch(0, 32'h11c, 1); #1; chk("R9 hit after fill", fetch_hit, 1); cycle();
    // refused read for thread 1
    fetch(1, 32'h208, 0); cycle();
    fetch(0, 32'h400, 1); cycle();
    idle(); cache_retry = 1; creq_ready = 0; cycle();
    // replay accepted while a stale response for thread 0 arrives
    idle(); cache_retry = 1; creq_ready = 1; resp(0, 0, {8{32'hDEAD_0000}}); cycle();
    idle(); resp(1, 4'd5, {8{32'hBAD0_0005}}); cycle();
    idle(); resp(1, 4'd1, {8{32'h1111_2222}}); cycle();
    // interrupt hold on aligned PC, allowed on PC with low bits set
    fetch(0, 32'h300, 1); irq_pending = 1; cycle();
    fetch(0, 32'h302, 1); irq_pending = 1; cycle();
    // squash coincides with the matching response
    idle(); squash = 2'b01; resp(0, 4'd2, {8{32'h3333_4444}}); cycle();
    chk("R8 squash cancels outstanding", waiting_o[0], 0);
    // squash of slot owner, then retry on empty slot
    fetch(0, 32'h500, 0); cycle();
    idle(); squash = 2'b01; cycle();
    #1; chk("R8 blocked kept after squash", cache_blocked, 1);
    @(negedge clk);
    idle(); cache_retry = 1; #1; chk("R7 nothing sent", creq_valid, 0); cycle();
    #1; chk("R7 blocked cleared", cache_blocked, 0);
    @(negedge clk);
    // tag wrap
    for (int i = 0; i < 18; i++) begin
      fetch(1, 32'h1000 + 32'(i) * 32'h40, 1); cycle();
      idle(); resp(1, m_oid[1], {8{32'(i)}}); cycle();
    end
    // random mix
    for (int i = 0; i < 600; i++) begin
      idle();
      fetch_req   = ($urandom % 3) != 0;
      fetch_tid   = 1'($urandom);
      fetch_pc    = ($urandom % 8) * 32'h20 + ($urandom % 32);
      irq_pending = ($urandom % 6) == 0;
      creq_ready  = ($urandom % 3) != 0;
      cache_retry = ($urandom % 4) == 0;
      squash      = (($urandom % 10) == 0) ? 2'(1 + $urandom % 3) : 2'b00;
      if (($urandom % 3) == 0) begin
        cresp_tid = 1'($urandom);
        resp(cresp_tid, (($urandom % 4) != 0) ? m_oid[cresp_tid] : 4'($urandom),
             {8{32'($urandom)}});
      end
      cycle();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule